// File: doc/BRIEF.md
# Interrupt Request Gatherer

This block collects interrupt requests from four kinds of source: a one-cycle timer overflow pulse, an external pin that is watched for an edge of selectable polarity, a small group of port pins checked against a snapshot, and a group of peripheral request lines. Each of the three core sources has a sticky flag and an enable bit in one 8-bit control word. Software writes and reads this word through a simple register port. A flag sets when its event occurs, whatever its enable bits say. Software clears a flag by writing 0 to it.

The peripheral lines arrive with their own enable mask. They pass through a second level of gating, the peripheral-group enable, before they can reach the CPU. A global enable sits above everything. The external pin and the port pins are asynchronous, so each passes through a two-flop synchronizer before any edge or mismatch logic sees it. The port snapshot is refreshed only by a port-read strobe. As long as the pins differ from the snapshot, the port-change flag keeps setting again, even after software clears it.

Top module: `irq_gather`

## Requirements
- R1: After a synchronous reset (port pins and external pin held low), the control word reads 0x00 and `cpu_irq` is 0.
- R2: A write stores bits 7:3 of the control word as written: bit 7 is the global enable, bit 6 the peripheral-group enable, bit 5 the timer enable, bit 4 the external-pin enable and bit 3 the port-change enable. The word reads back on the next cycle.
- R3: Flags sit at bit 2 (timer), bit 1 (external pin) and bit 0 (port change). A `tmr_ovf` pulse sets bit 2 on the next clock edge, even when every enable bit is 0.
- R4: A flag stays 1 until a write puts 0 in it. Writing 1 to a flag sets it.
- R5: If a write of 0 to a flag lands in the same cycle as that flag's event, the flag ends up 1.
- R6: With `ext_rise_sel`=1, a low-to-high change on `ext_pin` sets bit 1; with `ext_rise_sel`=0, a high-to-low change sets it. The opposite edge leaves bit 1 unchanged.
- R7: When the synchronized `chg_pins` differ from the snapshot, bit 0 sets. While the difference lasts, it sets again after software clears it.
- R8: A `port_rd` pulse copies the synchronized pins into the snapshot, which ends the mismatch. `port_val` always shows the synchronized pins.
- R9: `cpu_irq` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND any(`per_req` AND `per_ie`))). It is combinational from the control word and the peripheral inputs.
- R10: When bit 7 is 0, `cpu_irq` stays 0 whatever the flags and requests are, while the flags still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 8 | Value to write |
| reg_rdata | output | 8 | Current control word |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| ext_rise_sel | input | 1 | 1 = rising edge, 0 = falling edge |
| chg_pins | input | NCHG | Port pins watched for change, asynchronous |
| port_rd | input | 1 | Port read strobe, refreshes the snapshot |
| port_val | output | NCHG | Synchronized port pin value |
| per_req | input | NPER | Peripheral request lines |
| per_ie | input | NPER | Per-line peripheral enables |
| cpu_irq | output | 1 | Combined request to the CPU |

## Verification
The bench sweeps all 256 control words against a matching and a non-matching peripheral mask. A wrong gating term would raise `cpu_irq` while the global or group enable is clear, or would drop it for a pending source. It lands a flag-clearing write on the same cycle as a timer pulse; a design that gives the write priority would lose that event. It drives both edge directions under both polarities; inverted polarity logic would flag the wrong edge. It clears the port-change flag while the mismatch is still there, then again after a port read. A design that latches the flag only once would read 0 too early. One that never refreshes the snapshot would keep the flag stuck at 1.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

    localparam int CTL_W = 8;

    typedef struct packed {
        logic glb_en;
        logic grp_en;
        logic tov_en;
        logic ext_en;
        logic chg_en;
        logic tov_fl;
        logic ext_fl;
        logic chg_fl;
    } ctl_word_t;

    typedef struct packed {
        logic tov;
        logic ext;
        logic chg;
    } core_evt_t;

    function automatic logic core_pending(ctl_word_t c);
        return (c.tov_en & c.tov_fl) | (c.ext_en & c.ext_fl) | (c.chg_en & c.chg_fl);
    endfunction

    // Software write first, then events OR in so that none is lost.
    function automatic ctl_word_t ctl_next(ctl_word_t cur, logic wr,
                                           logic [CTL_W-1:0] wd, core_evt_t ev);
        ctl_word_t n;
        n = wr ? ctl_word_t'(wd) : cur;
        n.tov_fl = n.tov_fl | ev.tov;
        n.ext_fl = n.ext_fl | ev.ext;
        n.chg_fl = n.chg_fl | ev.chg;
        return n;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= '0;
                else     s_q <= d_in;
            end
            assign q_out = s_q;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_in};
            end
            assign q_out = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/irq_edge.sv
module irq_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic rise_sel,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign hit = rise_sel ? (lvl & ~prev_q) : (~lvl & prev_q);
endmodule

// File: rtl/irq_mismatch.sv
module irq_mismatch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic         snap_ld,
    output logic         hit
);
    logic [W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst)          snap_q <= '0;
        else if (snap_ld) snap_q <= pins;
    end

    assign hit = |(pins ^ snap_q);
endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int NPER        = 4,
    parameter int NCHG        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    output logic [CTL_W-1:0] reg_rdata,
    input  logic             tmr_ovf,
    input  logic             ext_pin,
    input  logic             ext_rise_sel,
    input  logic [NCHG-1:0]  chg_pins,
    input  logic             port_rd,
    output logic [NCHG-1:0]  port_val,
    input  logic [NPER-1:0]  per_req,
    input  logic [NPER-1:0]  per_ie,
    output logic             cpu_irq
);
    localparam int SW = NCHG + 1;

    logic [SW-1:0] raw_in;
    logic [SW-1:0] sync_in;
    logic          ext_s;
    logic [NCHG-1:0] chg_s;
    logic          ext_hit;
    logic          chg_hit;
    core_evt_t     evt;
    ctl_word_t     ctl_q;
    logic          grp_pending;

    assign raw_in = {ext_pin, chg_pins};

    irq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(raw_in), .q_out(sync_in)
    );

    assign ext_s = sync_in[SW-1];
    assign chg_s = sync_in[NCHG-1:0];

    irq_edge u_edge (
        .clk(clk), .rst(rst), .lvl(ext_s), .rise_sel(ext_rise_sel), .hit(ext_hit)
    );

    irq_mismatch #(.W(NCHG)) u_mis (
        .clk(clk), .rst(rst), .pins(chg_s), .snap_ld(port_rd), .hit(chg_hit)
    );

    always_comb begin
        evt.tov = tmr_ovf;
        evt.ext = ext_hit;
        evt.chg = chg_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_next(ctl_q, reg_wr, reg_wdata, evt);
    end

    assign grp_pending = ctl_q.grp_en & (|(per_req & per_ie));
    assign cpu_irq     = ctl_q.glb_en & (core_pending(ctl_q) | grp_pending);
    assign reg_rdata   = ctl_q;
    assign port_val    = chg_s;
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       tmr_ovf,
    input logic       chg_hit,
    input logic       cpu_irq
);
    p_reset_r1: assert property (@(posedge clk) rst |=> (reg_rdata == 8'h00));

    p_enables_r2: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata[7:3] == $past(reg_wdata[7:3])));

    p_tov_set_r3: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> reg_rdata[2]);

    p_sticky_tov_r4: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && reg_rdata[2]) |=> reg_rdata[2]);

    p_sticky_ext_r4: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && reg_rdata[1]) |=> reg_rdata[1]);

    p_no_loss_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[2] && tmr_ovf) |=> reg_rdata[2]);

    p_chg_set_r7: assert property (@(posedge clk) disable iff (rst)
        chg_hit |=> reg_rdata[0]);

    p_glb_gate_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> reg_rdata[7]);
endmodule

bind irq_gather irq_gather_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tmr_ovf(tmr_ovf), .chg_hit(chg_hit), .cpu_irq(cpu_irq)
);

// File: tb/tb_irq_gather.sv
module tb_irq_gather;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tmr_ovf = 1'b0;
    logic       ext_pin = 1'b0;
    logic       ext_rise_sel = 1'b1;
    logic [3:0] chg_pins = 4'h0;
    logic       port_rd = 1'b0;
    logic [3:0] port_val;
    logic [3:0] per_req = 4'h0;
    logic [3:0] per_ie = 4'h0;
    logic       cpu_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_gather dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
        .ext_rise_sel(ext_rise_sel), .chg_pins(chg_pins), .port_rd(port_rd),
        .port_val(port_val), .per_req(per_req), .per_ie(per_ie), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic model_irq(input logic [7:0] v, input logic [3:0] rq, input logic [3:0] ie);
        return v[7] & ((v[5] & v[2]) | (v[4] & v[1]) | (v[3] & v[0]) | (v[6] & (|(rq & ie))));
    endfunction

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        check("R1 ctl", reg_rdata, 8'h00);
        check("R1 irq", cpu_irq, 1'b0);

        // R2 R4 R9 sweep of all control words
        for (int v = 0; v < 256; v++) begin
            per_req = 4'b1010;
            per_ie  = 4'b0010;
            wr_ctl(v[7:0]);
            check("R2 R4 readback", reg_rdata, v[7:0]);
            check("R9 irq hit mask", cpu_irq, model_irq(v[7:0], per_req, per_ie));
            per_ie = 4'b0101;
            #1;
            check("R9 irq miss mask", cpu_irq, model_irq(v[7:0], per_req, per_ie));
        end

        // peripheral request sweep with group enable on and off
        for (int g = 0; g < 2; g++) begin
            wr_ctl(g ? 8'hC0 : 8'h80);
            for (int r = 0; r < 16; r++) begin
                for (int e = 0; e < 16; e++) begin
                    per_req = r[3:0];
                    per_ie  = e[3:0];
                    #1;
                    check("R9 group gate", cpu_irq, model_irq(reg_rdata, per_req, per_ie));
                end
            end
        end
        per_req = 4'h0;
        per_ie  = 4'h0;

        // R3 timer flag with every enable off
        wr_ctl(8'h00);
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        check("R3 timer flag", reg_rdata, 8'h04);
        cyc(5);
        check("R4 sticky", reg_rdata[2], 1'b1);
        wr_ctl(8'h00);
        check("R4 cleared", reg_rdata[2], 1'b0);

        // R5 clear write coincides with event
        wr_ctl(8'h04);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1;
        @(negedge clk); reg_wr = 1'b0; tmr_ovf = 1'b0;
        check("R5 no loss", reg_rdata[2], 1'b1);
        wr_ctl(8'h00);
        check("R5 plain clear", reg_rdata[2], 1'b0);

        // R10 global enable off: flag sets, irq stays low
        wr_ctl(8'h7F);
        per_req = 4'hF; per_ie = 4'hF;
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        check("R10 irq blocked", cpu_irq, 1'b0);
        check("R10 flag still set", reg_rdata[2], 1'b1);
        per_req = 4'h0; per_ie = 4'h0;
        wr_ctl(8'h00);

        // R6 edge polarity
        ext_rise_sel = 1'b1;
        @(negedge clk); ext_pin = 1'b1;
        cyc(4);
        check("R6 rising flagged", reg_rdata[1], 1'b1);
        wr_ctl(8'h00);
        @(negedge clk); ext_pin = 1'b0;
        cyc(4);
        check("R6 falling ignored when rising", reg_rdata[1], 1'b0);
        ext_rise_sel = 1'b0;
        @(negedge clk); ext_pin = 1'b1;
        cyc(4);
        check("R6 rising ignored when falling", reg_rdata[1], 1'b0);
        @(negedge clk); ext_pin = 1'b0;
        cyc(4);
        check("R6 falling flagged", reg_rdata[1], 1'b1);
        wr_ctl(8'h90);
        @(negedge clk); ext_pin = 1'b1;
        @(negedge clk); ext_pin = 1'b0;
        cyc(4);
        check("R9 ext irq", cpu_irq, 1'b1);
        wr_ctl(8'h00);

        // R7 R8 port change
        @(negedge clk); chg_pins = 4'b0101;
        cyc(4);
        check("R7 mismatch flag", reg_rdata[0], 1'b1);
        check("R8 port value", port_val, 4'b0101);
        wr_ctl(8'h00);
        cyc(1);
        check("R7 re-sets while mismatch", reg_rdata[0], 1'b1);
        @(negedge clk); port_rd = 1'b1;
        @(negedge clk); port_rd = 1'b0;
        wr_ctl(8'h00);
        cyc(3);
        check("R8 read ends mismatch", reg_rdata[0], 1'b0);
        @(negedge clk); chg_pins = 4'b0100;
        cyc(4);
        check("R7 single pin change", reg_rdata[0], 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule